// File: doc/BRIEF.md
# Serial Control Register with Path Decode

This block receives configuration bytes from a microcontroller over a three-wire write-only port: an active-low enable, a shift clock and a data line. While the enable is low, each rising edge of the shift clock moves one data bit into an 8-bit shifter, most significant bit first. The rising edge of the enable copies the shifter into the active control register. The register is decoded into three controls for an analog voice path:
- a one-hot selection for the transmit input multiplexer;
- separate enables for the differential receive driver and for the auxiliary receive output;
- a 3-bit receive attenuation code in 4 dB steps.

All three port wires are brought into the system clock domain through a synchronizer chain of SYNC_STAGES flops. Edges are detected there. An active-low power-down input resets the shifter, the register and the synchronizers asynchronously. The register then holds the default byte 0xA0 until a write completes after power-down is released. Each commit produces a one-cycle update pulse. The port has no back-pressure: the microcontroller may write at any time, and each enable rise commits exactly once.

Top module: `path_ctl_port`

## Requirements
- R1: While and after `pd_n` is low, the register holds 0xA0. The outputs then read `tx_sel`=4'b0010, `drv_en`=1, `aux_en`=0, `atten`=0 and `upd`=0.
- R2: While `cp_en` is low, each rising edge of `cp_clk` shifts `cp_dat` into the shifter. The first bit of a write ends in bit 7. The outputs do not change until `cp_en` rises.
- R3: Rising edges of `cp_clk` while `cp_en` is high leave the shifter unchanged. An enable rise with no bits shifted commits the previously shifted byte again.
- R4: When more than eight bits are shifted before `cp_en` rises, the last eight are committed.
- R5: Every commit raises `upd` for exactly one clock cycle, and the register changes only in the cycle of that pulse.
- R6: The transmit selection {bit6,bit7} decodes as follows: 00 gives `tx_sel`=4'b0001 (mute), 01 gives 4'b0010 (first input), 10 gives 4'b0100 (second input), and 11 gives 4'b1000 (sum of both inputs, each about 6 dB down).
- R7: `drv_en` follows bit 5 and `aux_en` follows bit 4. A cleared bit leaves that output at signal ground. Bit 3 has no effect.
- R8: `atten` = {bit2,bit1,bit0}, with bit 2 as the most significant bit. The receive gain is −4 dB times the code, from 0 to −28 dB.
- R9: A power-down in the middle of a write discards the partial shift. After release, the default decode is present, and an enable rise with no new bits commits 0xA0.
- R10: A committed byte appears at the outputs no later than SYNC_STAGES+2 clock cycles after the enable rise at the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pd_n | input | 1 | Active-low power-down; asynchronously loads the default byte |
| cp_en | input | 1 | Port enable; shifting while low, commit on rising edge |
| cp_clk | input | 1 | Port shift clock |
| cp_dat | input | 1 | Port serial data, MSB first |
| tx_sel | output | 4 | One-hot transmit select: mute, first, second, sum |
| drv_en | output | 1 | Differential receive driver enable |
| aux_en | output | 1 | Auxiliary receive output enable |
| atten | output | 3 | Receive attenuation code, 4 dB per step |
| upd | output | 1 | One-cycle pulse on each commit |

## Verification
A corrupted shifter cannot be seen at the ports until the next enable rise. It then shows as a wrong decode SYNC_STAGES+1 cycles later. A bench therefore has to commit after every stimulus that might have disturbed the shifter, including commits with no new bits. A corrupted committed register shows on `tx_sel`, `drv_en`, `aux_en` or `atten` at once, because the decode is combinational. A register that changes without an update pulse would show as `upd` counts that do not match the number of commits.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;
  localparam int CTL_W = 8;
  localparam int ATT_W = 3;
  localparam int TXS_W = 4;
  localparam logic [CTL_W-1:0] CTL_DEFAULT = 8'hA0;

  // Bit positions that the decoder relies on
  localparam int POS_TXA   = 7;
  localparam int POS_TXB   = 6;
  localparam int POS_DRV   = 5;
  localparam int POS_AUX   = 4;
  localparam int POS_SPARE = 3;
  localparam int POS_VOLHI = 2;

  typedef enum logic [TXS_W-1:0] {
    TX_MUTE = 4'b0001,
    TX_IN_A = 4'b0010,
    TX_IN_B = 4'b0100,
    TX_MIX  = 4'b1000
  } tx_sel_e;

  typedef struct packed {
    tx_sel_e          tx_sel;
    logic             drv_en;
    logic             aux_en;
    logic [ATT_W-1:0] atten;
  } path_ctl_t;
endpackage

// File: rtl/ctlp_sync.sv
module ctlp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] q_r;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= RST_VAL;
        else        q_r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= RST_VAL;
        else        q_r <= g_stage[g-1].q_r;
      end
    end
  end

  assign q = g_stage[STAGES-1].q_r;
endmodule

// File: rtl/ctlp_shift.sv
module ctlp_shift
  import ctlp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_s,
  input  logic             sclk_s,
  input  logic             sdat_s,
  output logic [CTL_W-1:0] ctrl_q,
  output logic             upd_q
);
  logic             en_d;
  logic             sclk_d;
  logic [CTL_W-1:0] shreg;
  logic             en_rise;
  logic             sclk_rise;

  assign en_rise   = en_s & ~en_d;
  assign sclk_rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d   <= 1'b1;
      sclk_d <= 1'b0;
      shreg  <= CTL_DEFAULT;
      ctrl_q <= CTL_DEFAULT;
      upd_q  <= 1'b0;
    end else begin
      en_d   <= en_s;
      sclk_d <= sclk_s;
      upd_q  <= en_rise;
      if (en_rise) ctrl_q <= shreg;
      if (sclk_rise && !en_s) shreg <= {shreg[CTL_W-2:0], sdat_s};
    end
  end

  AST_SHIFT_ONLY_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && en_d) |=> $stable(shreg)); // R3

  AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !en_s) |=> shreg[CTL_W-1:1] == $past(shreg[CTL_W-2:0])); // R2

  AST_NO_SILENT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |-> $stable(ctrl_q)); // R5

  AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q); // R5

  AST_DEFAULT_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_q == CTL_DEFAULT && shreg == CTL_DEFAULT)); // R9
endmodule

// File: rtl/ctlp_decode.sv
module ctlp_decode
  import ctlp_pkg::*;
(
  input  logic [CTL_W-1:0] ctrl,
  output path_ctl_t        path
);
  logic [1:0] tx_code;
  logic       unused_spare;

  assign tx_code      = {ctrl[POS_TXB], ctrl[POS_TXA]};
  assign unused_spare = ctrl[POS_SPARE];

  always_comb begin
    unique case (tx_code)
      2'b00:   path.tx_sel = TX_MUTE;
      2'b01:   path.tx_sel = TX_IN_A;
      2'b10:   path.tx_sel = TX_IN_B;
      default: path.tx_sel = TX_MIX;
    endcase
    path.drv_en = ctrl[POS_DRV];
    path.aux_en = ctrl[POS_AUX];
    path.atten  = ctrl[POS_VOLHI -: ATT_W];
  end

  always_comb begin
    AST_TXSEL_MATCH_CODE: assert ((path.tx_sel == TX_MUTE) == (ctrl[POS_TXA] == 1'b0 && ctrl[POS_TXB] == 1'b0)); // R6
  end
endmodule

// File: rtl/path_ctl_port.sv
module path_ctl_port
  import ctlp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             pd_n,
  input  logic             cp_en,
  input  logic             cp_clk,
  input  logic             cp_dat,
  output logic [TXS_W-1:0] tx_sel,
  output logic             drv_en,
  output logic             aux_en,
  output logic [ATT_W-1:0] atten,
  output logic             upd
);
  localparam int PORT_W = 3;
  localparam logic [PORT_W-1:0] PORT_IDLE = 3'b001; // {clk, dat, en}

  logic [PORT_W-1:0] port_s;
  logic [CTL_W-1:0]  ctrl_q;
  path_ctl_t         path;

  ctlp_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL(PORT_IDLE)) u_sync (
    .clk  (clk),
    .rst_n(pd_n),
    .d    ({cp_clk, cp_dat, cp_en}),
    .q    (port_s)
  );

  ctlp_shift u_shift (
    .clk   (clk),
    .rst_n (pd_n),
    .en_s  (port_s[0]),
    .sclk_s(port_s[2]),
    .sdat_s(port_s[1]),
    .ctrl_q(ctrl_q),
    .upd_q (upd)
  );

  ctlp_decode u_decode (
    .ctrl(ctrl_q),
    .path(path)
  );

  assign tx_sel = path.tx_sel;
  assign drv_en = path.drv_en;
  assign aux_en = path.aux_en;
  assign atten  = path.atten;

  AST_TXSEL_ONE_HOT: assert property (@(posedge clk) disable iff (!pd_n)
    $countones(tx_sel) == 1); // R6

  AST_OUTS_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (!pd_n)
    !upd |-> ($stable(tx_sel) && $stable(drv_en) && $stable(aux_en) && $stable(atten))); // R2
endmodule

// File: tb/path_ctl_port_tb_top.sv
module path_ctl_port_tb_top;
  logic clk = 1'b0;
  logic pd_n, cp_en, cp_clk, cp_dat;
  logic [3:0] tx_sel;
  logic drv_en, aux_en, upd;
  logic [2:0] atten;
  int checks = 0;
  int errors = 0;
  int upd_cnt = 0;
  int upd_exp = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  path_ctl_port dut_i (
    .clk(clk), .pd_n(pd_n), .cp_en(cp_en), .cp_clk(cp_clk), .cp_dat(cp_dat),
    .tx_sel(tx_sel), .drv_en(drv_en), .aux_en(aux_en), .atten(atten), .upd(upd)
  );

  always @(negedge clk) if (upd === 1'b1) upd_cnt++;

  // {byte, tx_sel, drv_en, aux_en, atten}
  localparam int NV = 10;
  localparam logic [16:0] VEC [NV] = '{
    {8'h00, 4'b0001, 1'b0, 1'b0, 3'd0},
    {8'h80, 4'b0010, 1'b0, 1'b0, 3'd0},
    {8'h40, 4'b0100, 1'b0, 1'b0, 3'd0},
    {8'hC0, 4'b1000, 1'b0, 1'b0, 3'd0},
    {8'h20, 4'b0001, 1'b1, 1'b0, 3'd0},
    {8'h10, 4'b0001, 1'b0, 1'b1, 3'd0},
    {8'h30, 4'b0001, 1'b1, 1'b1, 3'd0},
    {8'h07, 4'b0001, 1'b0, 1'b0, 3'd7},
    {8'h05, 4'b0001, 1'b0, 1'b0, 3'd5},
    {8'hEB, 4'b1000, 1'b1, 1'b0, 3'd3}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_outs(input string tag, input logic [8:0] exp);
    logic [8:0] act;
    act = {tx_sel, drv_en, aux_en, atten};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s outputs actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_upd(input string tag);
    checks++;
    if (upd_cnt != upd_exp) begin
      errors++;
      $display("FAIL %s update pulses actual=%0d expected=%0d", tag, upd_cnt, upd_exp);
    end
  endtask

  task automatic open_port();
    cp_en = 1'b0;
    tick(4);
  endtask

  task automatic shift_bits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      cp_dat = bits[i];
      tick(3);
      cp_clk = 1'b1;
      tick(3);
      cp_clk = 1'b0;
    end
  endtask

  task automatic commit();
    tick(4);
    cp_en = 1'b1;
    upd_exp++;
    tick(8);
  endtask

  task automatic write_byte(input logic [7:0] b);
    open_port();
    shift_bits({8'h00, b}, 8);
    commit();
  endtask

  localparam logic [8:0] DEF_OUT = {4'b0010, 1'b1, 1'b0, 3'd0};

  initial begin
    pd_n = 1'b0; cp_en = 1'b1; cp_clk = 1'b0; cp_dat = 1'b0;
    tick(5);
    pd_n = 1'b1;
    tick(4);
    check_outs("R1 default after power-down", DEF_OUT);
    check_upd("R1 no pulse at reset");

    // R2: no change before commit, MSB first
    open_port();
    shift_bits(16'h0030, 8);
    tick(6);
    check_outs("R2 outputs held before enable rise", DEF_OUT);
    commit();
    check_outs("R2 commit 0x30", {4'b0001, 1'b1, 1'b1, 3'd0});
    check_upd("R5 pulse after 0x30");

    // R10: exact latency of the commit
    open_port();
    shift_bits(16'h0080, 8);
    tick(4);
    cp_en = 1'b1;
    upd_exp++;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check_outs("R10 visible within SYNC_STAGES+2 cycles", {4'b0010, 1'b0, 1'b0, 3'd0});
    tick(6);

    // R6 R7 R8 decode table
    for (int v = 0; v < NV; v++) begin
      write_byte(VEC[v][16:9]);
      check_outs($sformatf("R6 R7 R8 vector %0d byte %h", v, VEC[v][16:9]), VEC[v][8:0]);
      check_upd($sformatf("R5 vector %0d", v));
    end

    // R3: shift clocks with enable high are ignored
    write_byte(8'h07);
    shift_bits(16'h00FF, 8);
    open_port();
    commit();
    check_outs("R3 clocks with enable high ignored", {4'b0001, 1'b0, 1'b0, 3'd7});
    check_upd("R3 R5 pulse on empty commit");

    // R4: extra bits, last eight kept
    open_port();
    shift_bits(16'h0790, 11);
    commit();
    check_outs("R4 last eight of eleven bits", {4'b0010, 1'b0, 1'b1, 3'd0});

    // R9: power-down mid write
    write_byte(8'hC7);
    check_outs("R9 setup 0xC7", {4'b1000, 1'b0, 1'b0, 3'd7});
    open_port();
    shift_bits(16'h0005, 4);
    pd_n = 1'b0;
    cp_en = 1'b1;
    tick(3);
    pd_n = 1'b1;
    tick(4);
    check_outs("R9 default after mid-write power-down", DEF_OUT);
    open_port();
    commit();
    check_outs("R9 partial shift discarded", DEF_OUT);
    check_upd("R9 R5 pulse count");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule